// File: doc/BRIEF.md
# End-of-Write Status Readback

This block sits in the read path of a byte-lane nonvolatile memory. A host can learn that a programming cycle has finished only by reading the memory. While a lane is busy programming, the block replaces that lane's read data with progress indicators. When the host reads the address that was written last, bit 7 comes back inverted. Bit 6 changes value on every new read, whatever the address. When the lane's busy flag drops, reads return the true array contents again, and bit 6 stops changing.

The block samples active-low chip select, output enable and write enable on its clock. Each lane has its own busy flag and its own copy of the last byte written. All lanes share one last-written address. The read data and the drive-enable come from registers and appear one clock after the strobes that request them. An external pad ring uses the drive-enable to switch between driving the bus and leaving it at high impedance. The programming engine that produces the busy flags and the held bytes is outside this block.

Top module: `eow_status_readback`

## Requirements
- R1: `rd_drive` is 1 in the cycle after a clock edge that samples `cs_n`=0, `oe_n`=0 and `we_n`=1, and 0 after any other sample. While `rd_drive` is 0, `rd_data` is all zeros.
- R2: For a lane whose `prog_busy` bit is 0, a read returns that lane's byte of `array_rdata` as sampled on the same edge, on all 8 bits.
- R3: For a busy lane, when `addr` equals `last_addr`, bit 7 of the lane byte (data bit 8*lane+7) is the inverse of bit 7 of that lane's byte in `last_wdata`.
- R4: For a busy lane, when `addr` equals `last_addr`, bits 5..0 of the lane byte equal bits 5..0 of that lane's held byte in `last_wdata`.
- R5: For a busy lane, bit 6 of the lane byte changes value at the start of every new read and keeps its value for as long as that read continues. A read starts on the first edge that samples the read condition of R1 after an edge that did not.
- R6: A new read can be started by raising and lowering either `oe_n` or `cs_n`. Both count the same way for R5.
- R7: For a busy lane, when `addr` differs from `last_addr`, bits 7 and 5..0 come from `array_rdata`, and bit 6 is the status bit of R5.
- R8: Each lane's status depends only on its own `prog_busy` bit. A lane that is not busy holds its bit-6 state across reads, so when programming ends the toggling stops and true data returns.
- R9: Reset (`rst_n`=0, asynchronous) clears `rd_drive` and `rd_data` and clears every lane's bit-6 state. The first busy read after reset therefore reports bit 6 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Read address |
| array_rdata | input | 8*LANES | Data read from the storage array |
| prog_busy | input | LANES | Per-lane flag: programming in progress |
| last_addr | input | ADDR_W | Address of the most recent write |
| last_wdata | input | 8*LANES | Most recent byte written, one per lane |
| rd_data | output | 8*LANES | Registered read data |
| rd_drive | output | 1 | 1 = drive `rd_data` onto the bus, 0 = high impedance |

## Verification
The hardest case to reach is a read that stays active across several clocks while a lane is busy. In that case bit 6 must not move. It must move only when a new read opens, and a new read can open from either an output-enable or a chip-select toggle. The stimulus holds reads open for several cycles and alternates between the two ways of reopening them. It also mixes busy and idle lanes in a single read, and drops busy between two reads so the bench can see the bit freeze. The reference model keeps its own per-lane parity count and edge tracking, and the bench compares against it on every clock.

// File: rtl/eow_pkg.sv
package eow_pkg;
  localparam int BYTE_W   = 8;
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;

  // Form one lane's read byte from the array byte, the held byte,
  // the address hit and the current status bit.
  function automatic logic [BYTE_W-1:0] status_byte(
    input logic [BYTE_W-1:0] arr,
    input logic [BYTE_W-1:0] held,
    input logic              hit,
    input logic              tog
  );
    logic [BYTE_W-1:0] b;
    b           = hit ? held : arr;
    b[POLL_BIT] = hit ? ~held[POLL_BIT] : arr[POLL_BIT];
    b[TOG_BIT]  = tog;
    return b;
  endfunction

  // Read condition taken from the three active-low strobes.
  function automatic logic read_cond(input logic cs_n, input logic oe_n,
                                     input logic we_n);
    return ~cs_n & ~oe_n & we_n;
  endfunction
endpackage

// File: rtl/eow_read_strobe.sv
module eow_read_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_act,
  output logic rd_start
);
  import eow_pkg::*;
  logic act_q;

  assign rd_act   = read_cond(cs_n, oe_n, we_n);
  assign rd_start = rd_act & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= rd_act;
  end
endmodule

// File: rtl/eow_addr_match.sv
module eow_addr_match #(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] last_addr,
  output logic              hit
);
  assign hit = (addr == last_addr);
endmodule

// File: rtl/eow_lane_status.sv
module eow_lane_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       rd_start,
  input  logic       hit,
  input  logic [7:0] arr_byte,
  input  logic [7:0] held_byte,
  output logic [7:0] lane_byte,
  output logic       tog_q
);
  import eow_pkg::*;
  logic tog_next;

  // The status bit advances only at the opening of a read on a busy lane.
  assign tog_next = tog_q ^ (busy & rd_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_next;
  end

  assign lane_byte = busy ? status_byte(arr_byte, held_byte, hit, tog_next)
                          : arr_byte;
endmodule

// File: rtl/eow_status_readback.sv
module eow_status_readback #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 oe_n,
  input  logic                 we_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [8*LANES-1:0]   array_rdata,
  input  logic [LANES-1:0]     prog_busy,
  input  logic [ADDR_W-1:0]    last_addr,
  input  logic [8*LANES-1:0]   last_wdata,
  output logic [8*LANES-1:0]   rd_data,
  output logic                 rd_drive
);
  import eow_pkg::*;
  localparam int DATA_W = BYTE_W * LANES;

  logic              rd_act;
  logic              rd_start;
  logic              addr_hit;
  logic [LANES-1:0]  tog_state;
  logic [DATA_W-1:0] lane_bytes;

  eow_read_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .rd_act(rd_act), .rd_start(rd_start)
  );

  eow_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .addr(addr), .last_addr(last_addr), .hit(addr_hit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    eow_lane_status u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (prog_busy[l]),
      .rd_start (rd_start),
      .hit      (addr_hit),
      .arr_byte (array_rdata[l*BYTE_W +: BYTE_W]),
      .held_byte(last_wdata[l*BYTE_W +: BYTE_W]),
      .lane_byte(lane_bytes[l*BYTE_W +: BYTE_W]),
      .tog_q    (tog_state[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_drive <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_drive <= rd_act;
      rd_data  <= rd_act ? lane_bytes : '0;
    end
  end
endmodule

// File: rtl/eow_status_readback_chk.sv
module eow_status_readback_chk #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n,
  input logic                oe_n,
  input logic                we_n,
  input logic [ADDR_W-1:0]   addr,
  input logic [8*LANES-1:0]  array_rdata,
  input logic [LANES-1:0]    prog_busy,
  input logic [ADDR_W-1:0]   last_addr,
  input logic [8*LANES-1:0]  last_wdata,
  input logic [8*LANES-1:0]  rd_data,
  input logic                rd_drive,
  input logic                rd_start,
  input logic                addr_hit,
  input logic [LANES-1:0]    tog_state
);
  logic cond;
  assign cond = !cs_n && !oe_n && we_n;

  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> rd_data == '0);

  assert_drive_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cond |=> rd_drive);

  assert_drive_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> !rd_drive);

  assert_true_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && prog_busy == '0) |=> rd_data == $past(array_rdata));

  assert_poll_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && prog_busy[0] && addr == last_addr)
      |=> rd_data[7] != $past(last_wdata[7]));

  assert_toggle_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && prog_busy[0]) |=> tog_state[0] != $past(tog_state[0]));

  assert_toggle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(tog_state));

  assert_idle_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy == '0) |=> $stable(tog_state));

  assert_miss_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && prog_busy[0] && !addr_hit)
      |=> rd_data[7] == $past(array_rdata[7]));
endmodule

bind eow_status_readback eow_status_readback_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (.*);

// File: tb/eow_status_readback_bench.sv
module eow_status_readback_bench;
  localparam int ADDR_W = 17;
  localparam int LANES  = 4;
  localparam int DW     = 8*LANES;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0, last_addr = '0;
  logic [DW-1:0]     array_rdata = '0, last_wdata = '0;
  logic [LANES-1:0]  prog_busy = '0;
  logic [DW-1:0]     rd_data;
  logic              rd_drive;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  eow_status_readback #(.ADDR_W(ADDR_W), .LANES(LANES)) u_eow_status_readback (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .array_rdata(array_rdata), .prog_busy(prog_busy),
    .last_addr(last_addr), .last_wdata(last_wdata),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: per-lane parity counters and a remembered read level.
  int     par [LANES];
  bit     was_reading = 0;
  bit     exp_drive = 0;
  logic [7:0] exp_byte [LANES];
  string  exp_tag [LANES];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_reading = 0;
      exp_drive   = 0;
      for (int l = 0; l < LANES; l++) begin
        par[l] = 0; exp_byte[l] = 8'h00; exp_tag[l] = "R9";
      end
    end else begin
      bit reading, opening, same;
      reading = (cs_n == 0) && (oe_n == 0) && (we_n == 1);
      opening = reading && !was_reading;
      same    = (addr == last_addr);
      for (int l = 0; l < LANES; l++) begin
        logic [7:0] a, h;
        a = array_rdata[8*l +: 8];
        h = last_wdata[8*l +: 8];
        if (prog_busy[l] && opening) par[l] = par[l] + 1;
        if (!reading) begin
          exp_byte[l] = 8'h00; exp_tag[l] = "R1";
        end else if (!prog_busy[l]) begin
          exp_byte[l] = a; exp_tag[l] = "R2 R8";
        end else if (same) begin
          exp_byte[l] = {~h[7], par[l][0], h[5:0]}; exp_tag[l] = "R3 R4 R5 R6";
        end else begin
          exp_byte[l] = {a[7], par[l][0], a[5:0]}; exp_tag[l] = "R7 R5 R6";
        end
      end
      exp_drive   = reading;
      was_reading = reading;
    end
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      check("R1 drive", {31'b0, rd_drive}, {31'b0, exp_drive});
      for (int l = 0; l < LANES; l++)
        check(exp_tag[l], {24'b0, rd_data[8*l +: 8]}, {24'b0, exp_byte[l]});
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // One read held open for `len` cycles, reopened by oe_n or by cs_n.
  task automatic do_read(logic [ADDR_W-1:0] a, int len, bit by_cs,
                         output logic [DW-1:0] seen);
    addr = a;
    if (by_cs) begin oe_n = 0; cs_n = 0; end
    else       begin cs_n = 0; oe_n = 0; end
    @(posedge clk); @(negedge clk); seen = rd_data;
    #4;
    tick(len - 1);
    if (by_cs) cs_n = 1; else oe_n = 1;
    tick(1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r1, r2, r3;
    tick(3);
    check("R9 drive in reset", {31'b0, rd_drive}, 32'd0);
    check("R9 data in reset", rd_data, 32'd0);
    rst_n = 1; tick(2);

    // R2: idle reads of several patterns
    array_rdata = 32'hA5C3_0FF0; do_read(17'h00100, 2, 0, r1);
    check("R2 idle read", r1, 32'hA5C3_0FF0);
    array_rdata = 32'h1234_5678; do_read(17'h1FFFF, 3, 1, r1);
    check("R2 idle read cs", r1, 32'h1234_5678);

    // Programming starts on all lanes
    last_addr = 17'h05555; last_wdata = 32'h80FF_3C41;
    array_rdata = 32'hFFFF_FFFF; prog_busy = 4'hF;
    do_read(17'h05555, 3, 0, r1);
    check("R9 first status bit", {31'b0, r1[6]}, 32'd1);
    check("R3 inverted bit7", {31'b0, r1[7]}, {31'b0, ~last_wdata[7]});
    check("R4 low bits", {26'b0, r1[5:0]}, {26'b0, last_wdata[5:0]});
    do_read(17'h05555, 4, 0, r2);
    check("R5 oe reopen flips", {31'b0, r2[6]}, {31'b0, ~r1[6]});
    do_read(17'h05555, 2, 1, r3);
    check("R6 cs reopen flips", {31'b0, r3[6]}, {31'b0, ~r2[6]});

    // R7: other address during busy
    array_rdata = 32'h0F0F_7E81; do_read(17'h00002, 2, 1, r1);
    check("R7 miss bit7", {31'b0, r1[7]}, 32'd1);
    check("R7 miss low bits", {26'b0, r1[5:0]}, 32'h01);

    // write enable low blocks the read
    we_n = 0; cs_n = 0; oe_n = 0; tick(3);
    check("R1 we low no drive", {31'b0, rd_drive}, 32'd0);
    cs_n = 1; oe_n = 1; we_n = 1; tick(1);

    // R8: mixed lanes
    prog_busy = 4'b0101; array_rdata = 32'hC0DE_BEEF;
    do_read(17'h05555, 2, 0, r1);
    check("R8 idle lane1 true", {24'b0, r1[15:8]}, 32'hBE);
    check("R8 idle lane3 true", {24'b0, r1[31:24]}, 32'hC0);
    do_read(17'h05555, 2, 1, r2);
    check("R8 busy lane0 flips", {31'b0, r2[6]}, {31'b0, ~r1[6]});

    // programming ends: true data, bit 6 frozen
    prog_busy = 4'h0; array_rdata = 32'h4040_4040;
    do_read(17'h05555, 2, 0, r1);
    check("R8 done true data", r1, 32'h4040_4040);
    prog_busy = 4'h2; array_rdata = 32'h0000_0000;
    do_read(17'h00001, 2, 0, r1);
    do_read(17'h00001, 2, 1, r2);
    check("R5 lane1 alternates", {31'b0, r2[14]}, {31'b0, ~r1[14]});
    prog_busy = 4'h0; tick(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule